// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This block rearranges the bytes of a 32-bit operand and reports four status flags about the rearranged value. A 2-bit operation select picks one of three permutations:

- **Byte swap per halfword:** the two bytes inside each halfword trade places.
- **Full byte reversal:** the byte order of the whole word is reversed.
- **Halfword exchange:** the upper and lower halfwords trade places.

A fourth select code passes the operand through unchanged.

The permutation and the flag logic are combinational. Both feed a single output register. An input strobe marks each valid operand, and the result, the flags and an output strobe appear one clock later. When no operand is presented, the registered result and flags keep their last value.

The zero flag and the sign flag have the same meaning for every permutation. The carry flag is different for each operation. For each permutation it detects a zero byte or a zero halfword in a different part of the result. The overflow flag is always cleared. A datapath uses the unit as a one-stage execution slot for byte-order conversion and null-byte scanning.

Top module: `lane_swap_unit`

## Requirements
- R1: A synchronous active-high reset clears `res_data`, all four flags and `res_valid` to 0 at the next rising clock edge.
- R2: With `op_sel` = 2'b00, the result is {in[23:16], in[31:24], in[7:0], in[15:8]}. The carry flag is 1 exactly when result bits 7:0 are all zero.
- R3: With `op_sel` = 2'b01, the result is {in[7:0], in[15:8], in[23:16], in[31:24]}. The carry flag is 1 exactly when ((r - 32'h01010101) & ~r & 32'h80808080) is non-zero for result r, that is, when any result byte is zero.
- R4: With `op_sel` = 2'b10, the result is {in[15:0], in[31:16]}. The carry flag is 1 exactly when result bits 15:0 or result bits 31:16 are all zero.
- R5: For `op_sel` 2'b00, 2'b01 and 2'b10, the zero flag is 1 exactly when the 32-bit result is all zero. The sign flag equals result bit 31.
- R6: The overflow flag is 0 after every operation.
- R7: With `op_sel` = 2'b11, the result equals the operand and all four flags are 0.
- R8: `res_valid` equals `op_valid` delayed by exactly one clock.
- R9: While `op_valid` is low, `res_data` and all four flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Marks `op_data` and `op_sel` as valid this cycle |
| op_sel | input | 2 | Operation: 00 byte swap per halfword, 01 full reversal, 10 halfword exchange, 11 pass-through |
| op_data | input | 32 | Operand |
| res_valid | output | 1 | Result strobe, one clock after `op_valid` |
| res_data | output | 32 | Registered result |
| res_zero | output | 1 | Zero flag |
| res_sign | output | 1 | Sign flag |
| res_carry | output | 1 | Operation-specific zero-byte or zero-halfword flag |
| res_ovf | output | 1 | Overflow flag, always 0 |

## Verification
Every result, flag and the output strobe is due on the first rising edge after the operand is presented, because exactly one register lies on each path.

The bench drives inputs on falling edges. On each rising edge it updates a behavioural expectation with the same one-edge latency, and it compares all outputs at the following falling edge. In this way every cycle is checked once, including cycles in which holding (R9) or reset (R1) is the expected behaviour.

// File: rtl/lane_swap_pkg.sv
package lane_swap_pkg;

  typedef enum logic [1:0] {
    OP_HALF_BSWAP = 2'b00,
    OP_WORD_REV   = 2'b01,
    OP_HALF_XCHG  = 2'b10,
    OP_PASS       = 2'b11
  } swap_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } swap_flags_t;

endpackage

// File: rtl/lane_permute.sv
module lane_permute
  import lane_swap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  swap_op_e          op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o
);

  localparam int NUM_LANES      = DATA_W / LANE_W;
  localparam int LANES_PER_HALF = NUM_LANES / 2;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int HALF_IDX  = i / LANES_PER_HALF;
    localparam int POS       = i % LANES_PER_HALF;
    localparam int SRC_BSWAP = HALF_IDX * LANES_PER_HALF + (LANES_PER_HALF - 1 - POS);
    localparam int SRC_REV   = NUM_LANES - 1 - i;
    localparam int SRC_XCHG  = (i + LANES_PER_HALF) % NUM_LANES;

    logic [LANE_W-1:0] sel;

    always_comb begin
      case (op_i)
        OP_HALF_BSWAP: sel = data_i[SRC_BSWAP*LANE_W +: LANE_W];
        OP_WORD_REV:   sel = data_i[SRC_REV*LANE_W +: LANE_W];
        OP_HALF_XCHG:  sel = data_i[SRC_XCHG*LANE_W +: LANE_W];
        default:       sel = data_i[i*LANE_W +: LANE_W];
      endcase
    end

    assign result_o[i*LANE_W +: LANE_W] = sel;
  end

endmodule

// File: rtl/lane_flag_gen.sv
module lane_flag_gen
  import lane_swap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  swap_op_e          op_i,
  input  logic [DATA_W-1:0] result_i,
  output swap_flags_t       flags_o
);

  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int HALF_W    = DATA_W / 2;

  logic [NUM_LANES-1:0] lane_zero;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_zdet
    assign lane_zero[i] = (result_i[i*LANE_W +: LANE_W] == '0);
  end

  logic low_half_zero;
  logic high_half_zero;

  assign low_half_zero  = (result_i[HALF_W-1:0] == '0);
  assign high_half_zero = (result_i[DATA_W-1:HALF_W] == '0);

  always_comb begin
    flags_o       = '0;
    flags_o.zero  = low_half_zero & high_half_zero;
    flags_o.sign  = result_i[DATA_W-1];
    flags_o.ovf   = 1'b0;
    case (op_i)
      OP_HALF_BSWAP: flags_o.carry = lane_zero[0];
      OP_WORD_REV:   flags_o.carry = |lane_zero;
      OP_HALF_XCHG:  flags_o.carry = low_half_zero | high_half_zero;
      default:       flags_o       = '0;
    endcase
  end

endmodule

// File: rtl/lane_out_reg.sv
module lane_out_reg
  import lane_swap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  swap_flags_t       flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output swap_flags_t       flags_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        data_o  <= data_i;
        flags_o <= flags_i;
      end
    end
  end

endmodule

// File: rtl/lane_swap_unit.sv
module lane_swap_unit
  import lane_swap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] op_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_zero,
  output logic              res_sign,
  output logic              res_carry,
  output logic              res_ovf
);

  swap_op_e          op_enum;
  logic [DATA_W-1:0] perm_data;
  swap_flags_t       perm_flags;
  swap_flags_t       reg_flags;

  assign op_enum = swap_op_e'(op_sel);

  lane_permute #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_permute (
    .op_i     (op_enum),
    .data_i   (op_data),
    .result_o (perm_data)
  );

  lane_flag_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_flags (
    .op_i     (op_enum),
    .result_i (perm_data),
    .flags_o  (perm_flags)
  );

  lane_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (op_valid),
    .data_i  (perm_data),
    .flags_i (perm_flags),
    .valid_o (res_valid),
    .data_o  (res_data),
    .flags_o (reg_flags)
  );

  assign res_zero  = reg_flags.zero;
  assign res_sign  = reg_flags.sign;
  assign res_carry = reg_flags.carry;
  assign res_ovf   = reg_flags.ovf;

endmodule

// File: rtl/lane_swap_unit_chk.sv
module lane_swap_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op_sel,
  input logic [DATA_W-1:0] op_data,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_zero,
  input logic              res_sign,
  input logic              res_carry,
  input logic              res_ovf
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !res_ovf);  // R6

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(op_valid)));  // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid)) |->
      ($stable(res_data) && $stable(res_zero) && $stable(res_sign) && $stable(res_carry)));  // R9

  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && ($past(op_sel) != 2'b11)) |->
      ((res_zero == (res_data == '0)) && (res_sign == res_data[DATA_W-1])));  // R5

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && ($past(op_sel) == 2'b11)) |->
      ((res_data == $past(op_data)) && !res_zero && !res_sign && !res_carry));  // R7

  AST_HALF_XCHG_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && ($past(op_sel) == 2'b10)) |->
      (res_data == {$past(op_data[15:0]), $past(op_data[31:16])}));  // R4

  AST_WORD_REV_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && ($past(op_sel) == 2'b01)) |->
      (res_data == {$past(op_data[7:0]), $past(op_data[15:8]),
                    $past(op_data[23:16]), $past(op_data[31:24])}));  // R3

  AST_HALF_BSWAP_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && ($past(op_sel) == 2'b00)) |->
      ((res_data == {$past(op_data[23:16]), $past(op_data[31:24]),
                     $past(op_data[7:0]), $past(op_data[15:8])}) &&
       (res_carry == (res_data[7:0] == 8'h00))));  // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && (res_data == '0) && !res_zero && !res_sign && !res_carry && !res_ovf));  // R1

endmodule

bind lane_swap_unit lane_swap_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .op_data   (op_data),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_zero  (res_zero),
  .res_sign  (res_sign),
  .res_carry (res_carry),
  .res_ovf   (res_ovf)
);

// File: tb/lane_swap_unit_test.sv
`timescale 1ns/1ps
module lane_swap_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] op_data = 32'h0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_zero, res_sign, res_carry, res_ovf;

  int checks   = 0;
  int failures = 0;

  logic        exp_valid = 1'b0;
  logic [31:0] exp_data  = 32'h0;
  logic [3:0]  exp_flags = 4'h0;  // {zero, sign, carry, ovf}

  always #2 clk = ~clk;  // 250 MHz

  lane_swap_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .op_data(op_data),
    .res_valid(res_valid), .res_data(res_data), .res_zero(res_zero),
    .res_sign(res_sign), .res_carry(res_carry), .res_ovf(res_ovf)
  );

  function automatic void ref_op(input logic [1:0] op, input logic [31:0] x,
                                 output logic [31:0] r, output logic [3:0] f);
    logic c;
    case (op)
      2'd0: r = {x[23:16], x[31:24], x[7:0], x[15:8]};
      2'd1: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
      2'd2: r = {x[15:0], x[31:16]};
      default: r = x;
    endcase
    case (op)
      2'd0: c = (r[7:0] == 8'h00);
      2'd1: c = (((r - 32'h01010101) & ~r & 32'h80808080) != 32'h0);
      2'd2: c = (r[15:0] == 16'h0) || (r[31:16] == 16'h0);
      default: c = 1'b0;
    endcase
    if (op == 2'd3) f = 4'h0;
    else f = {(r == 32'h0), r[31], c, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [1:0] op, input logic [31:0] d);
    logic [31:0] rr;
    logic [3:0]  ff;
    string dtag, ctag;
    rst = r; op_valid = v; op_sel = op; op_data = d;
    @(posedge clk);
    if (r) begin
      exp_valid = 1'b0; exp_data = 32'h0; exp_flags = 4'h0;
      dtag = "R1"; ctag = "R1";
    end else begin
      exp_valid = v;
      if (v) begin
        ref_op(op, d, rr, ff);
        exp_data = rr; exp_flags = ff;
        case (op)
          2'd0: dtag = "R2";
          2'd1: dtag = "R3";
          2'd2: dtag = "R4";
          default: dtag = "R7";
        endcase
        ctag = dtag;
      end else begin
        dtag = "R9"; ctag = "R9";
      end
    end
    @(negedge clk);
    check({dtag, " data"}, res_data, exp_data);
    check({ctag, " carry"}, {31'h0, res_carry}, {31'h0, exp_flags[1]});
    check(r ? "R1 zero" : (v && op != 2'd3) ? "R5 zero" : {ctag, " zero"},
          {31'h0, res_zero}, {31'h0, exp_flags[3]});
    check(r ? "R1 sign" : (v && op != 2'd3) ? "R5 sign" : {ctag, " sign"},
          {31'h0, res_sign}, {31'h0, exp_flags[2]});
    check(r ? "R1 ovf" : "R6 ovf", {31'h0, res_ovf}, {31'h0, exp_flags[0]});
    check(r ? "R1 valid" : "R8 valid", {31'h0, res_valid}, {31'h0, exp_valid});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, even with a strobe present
    step(1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    // R2/R3/R4/R7 main patterns
    step(1'b0, 1'b1, 2'd0, 32'h1122_3344);
    step(1'b0, 1'b1, 2'd1, 32'h1122_3344);
    step(1'b0, 1'b1, 2'd2, 32'h1122_3344);
    step(1'b0, 1'b1, 2'd3, 32'h8122_3344);
    // R2 carry: low result byte zero vs. other byte zero only
    step(1'b0, 1'b1, 2'd0, 32'h1234_0056);
    step(1'b0, 1'b1, 2'd0, 32'h0000_1200);
    // R3 carry: one inner zero byte; none
    step(1'b0, 1'b1, 2'd1, 32'h1200_3456);
    step(1'b0, 1'b1, 2'd1, 32'h0101_0101);
    // R5 sign and R3 carry from reversal of 0x80
    step(1'b0, 1'b1, 2'd1, 32'h0000_0080);
    // R4 carry: zero upper half input; no zero half
    step(1'b0, 1'b1, 2'd2, 32'h0000_ABCD);
    step(1'b0, 1'b1, 2'd2, 32'h0100_0001);
    // R5 zero flag for each permutation
    step(1'b0, 1'b1, 2'd0, 32'h0);
    step(1'b0, 1'b1, 2'd1, 32'h0);
    step(1'b0, 1'b1, 2'd2, 32'h0);
    // R7: zero operand on pass-through gives no flags
    step(1'b0, 1'b1, 2'd3, 32'h0);
    // R9: hold with garbage on the inputs
    step(1'b0, 1'b1, 2'd2, 32'hF00D_0000);
    step(1'b0, 1'b0, 2'd1, 32'hDEAD_BEEF);
    step(1'b0, 1'b0, 2'd3, 32'h0);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 4) == 0) d[8*($urandom % 4) +: 8] = 8'h00;
      step(1'b0, ($urandom % 3) != 0, 2'($urandom % 4), d);
    end
    // R1: reset mid-run clears a loaded result
    step(1'b0, 1'b1, 2'd1, 32'h8899_AABB);
    step(1'b1, 1'b0, 2'd0, 32'h0);
    step(1'b0, 1'b0, 2'd0, 32'h1234_5678);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule